// File: doc/BRIEF.md
# Universal Registered Bus Transceiver

The block moves an 18-bit word between two buses, A and B, with a separate data path in each direction. Data is never inverted. Each path has four control inputs: an active-low output enable, a latch enable, an active-low clock enable and a path clock that acts on its falling edge.

Each path can work in one of three ways. In transparent mode, the opposite bus follows the input bus directly. In hold mode, the path drives a stored word. In registered mode, the stored word is reloaded on an enabled falling edge of the path clock. Each bus is split into an input vector, an output vector and a drive flag. A wrapper at the pad ring turns these into tri-state pins.

The path clocks are slow control signals. The block samples them with its own system clock and detects the falling edges in that clock domain. When reset is asserted, both stored words are cleared and both drivers are switched off. Because the block is a bus transceiver with no flow control, every pin is a plain level: there is no valid/ready interface.

Top module: `regbus_xcvr`

## Requirements
- R1: The path width is 18 bits by default and transfers are non-inverting. Every bit of the output equals the same bit of the selected source, including bit 17 and bit 0.
- R2: When a path's output enable `*_oe_n` is 1, that path's drive flag is 0 and its output vector reads zero, whatever the other inputs are. The stored word can still be loaded while the driver is off, and it appears as soon as the enable returns to 0.
- R3: When a path's latch enable is 1, the output equals the input bus in the same cycle, with no clock edge needed. At every system clock edge the stored word takes the input value.
- R4: When the latch enable is 0 and the path clock stays at one level, the output holds the stored word while the input bus changes.
- R5: When the latch enable is 0 and `*_cke_n` is 0, a falling edge of the path clock loads the input. The edge is seen as a 1 sample followed by a 0 sample at two successive system clock edges, and the load uses the input present at the edge that samples the 0. The output shows the new word right after that edge.
- R6: When `*_cke_n` is 1, a falling path-clock edge loads nothing.
- R7: A rising edge of the path clock loads nothing.
- R8: When the latch enable falls, the path keeps the last word that passed through it, which is the input at the last system clock edge with the latch enable at 1.
- R9: While `rst_n` is 0 (asynchronous, active low), both drive flags are 0 and both stored words are cleared to zero. After release, with the latch enables at 0, both outputs read zero.
- R10: The two paths are independent. Loading or changing the B-to-A path leaves the A-to-B output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the path clocks |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| a_in | input | 18 | Word seen on bus A |
| a_out | output | 18 | Word driven onto bus A (B-to-A path) |
| a_drive | output | 1 | Driver enable for bus A |
| b_in | input | 18 | Word seen on bus B |
| b_out | output | 18 | Word driven onto bus B (A-to-B path) |
| b_drive | output | 1 | Driver enable for bus B |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch enable (1 = transparent) |
| ab_cke_n | input | 1 | A-to-B clock enable, active low |
| ab_pclk | input | 1 | A-to-B path clock, falling edge active |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable (1 = transparent) |
| ba_cke_n | input | 1 | B-to-A clock enable, active low |
| ba_pclk | input | 1 | B-to-A path clock, falling edge active |

## Verification
The bench aims at edges that must not load data: a rising path clock, a falling edge while the clock enable is off, and an enable turned on while the path clock sits low. A design that detected levels instead of edges, or ignored the enable, would show the new input word in those cases. It checks that leaving transparent mode keeps the last word that passed through; a design that cleared or froze the word early would show an older value. It also checks that a word loaded with the driver off appears when the driver comes back, that one path leaves the other alone, and that reset clears both words and switches off both drivers.

// File: rtl/regbus_xcvr_pkg.sv
package regbus_xcvr_pkg;
  localparam int unsigned BUS_W = 18;

  // Control set of one direction
  typedef struct packed {
    logic oe_n;
    logic le;
    logic cke_n;
    logic pclk;
  } path_ctl_t;

  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_KEEP = 2'd1,
    MODE_LOAD = 2'd2
  } path_mode_t;
endpackage

// File: rtl/regbus_fall_det.sv
module regbus_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign fall = prev_q & ~lvl;

  // R5
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/regbus_path.sv
module regbus_path
  import regbus_xcvr_pkg::*;
#(
  parameter int unsigned W = BUS_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  path_ctl_t    ctl,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         drive
);
  logic         fall;
  logic [W-1:0] store_q;
  path_mode_t   mode;

  regbus_fall_det u_fall (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (ctl.pclk),
    .fall  (fall)
  );

  always_comb begin
    if (ctl.le)                     mode = MODE_PASS;
    else if (fall && !ctl.cke_n)    mode = MODE_LOAD;
    else                            mode = MODE_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  store_q <= '0;
    else if (mode != MODE_KEEP)  store_q <= din;
  end

  assign drive = rst_n & ~ctl.oe_n;
  assign dout  = drive ? (ctl.le ? din : store_q) : '0;

  // R3 R8
  track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.le |=> (store_q == $past(din)));

  // R5
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.le && !ctl.cke_n && fall) |=> (store_q == $past(din)));

  // R6
  cke_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.le && ctl.cke_n) |=> $stable(store_q));

  // R4 R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.le && !fall) |=> $stable(store_q));
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
  import regbus_xcvr_pkg::*;
#(
  parameter int unsigned W = BUS_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_drive,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_drive,
  input  logic         ab_oe_n,
  input  logic         ab_le,
  input  logic         ab_cke_n,
  input  logic         ab_pclk,
  input  logic         ba_oe_n,
  input  logic         ba_le,
  input  logic         ba_cke_n,
  input  logic         ba_pclk
);
  path_ctl_t ab_ctl, ba_ctl;

  assign ab_ctl = '{oe_n: ab_oe_n, le: ab_le, cke_n: ab_cke_n, pclk: ab_pclk};
  assign ba_ctl = '{oe_n: ba_oe_n, le: ba_le, cke_n: ba_cke_n, pclk: ba_pclk};

  regbus_path #(.W(W)) u_ab (
    .clk   (clk),
    .rst_n (rst_n),
    .ctl   (ab_ctl),
    .din   (a_in),
    .dout  (b_out),
    .drive (b_drive)
  );

  regbus_path #(.W(W)) u_ba (
    .clk   (clk),
    .rst_n (rst_n),
    .ctl   (ba_ctl),
    .din   (b_in),
    .dout  (a_out),
    .drive (a_drive)
  );

  // R9
  reset_off_chk: assert property (@(posedge clk)
    !rst_n |-> (!a_drive && !b_drive));

  // R2
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_oe_n |-> (!b_drive && b_out == '0)) and (ba_oe_n |-> (!a_drive && a_out == '0)));
endmodule

// File: tb/tb_regbus_xcvr.sv
module tb_regbus_xcvr;
  localparam int W = 18;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_drive, b_drive;
  logic ab_oe_n = 1'b0, ab_le = 1'b0, ab_cke_n = 1'b1, ab_pclk = 1'b0;
  logic ba_oe_n = 1'b0, ba_le = 1'b0, ba_cke_n = 1'b1, ba_pclk = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  logic [W-1:0] exp_store [2];

  regbus_xcvr #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
    .b_in(b_in), .b_out(b_out), .b_drive(b_drive),
    .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_cke_n(ab_cke_n), .ab_pclk(ab_pclk),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_cke_n(ba_cke_n), .ba_pclk(ba_pclk)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  // dir 0: A-to-B (input a_in, output b_out); dir 1: B-to-A
  task automatic set_ctl(input int d, input logic oe_n, le, cke_n, pclk);
    if (d == 0) begin ab_oe_n = oe_n; ab_le = le; ab_cke_n = cke_n; ab_pclk = pclk; end
    else        begin ba_oe_n = oe_n; ba_le = le; ba_cke_n = cke_n; ba_pclk = pclk; end
  endtask

  task automatic set_in(input int d, input logic [W-1:0] v);
    if (d == 0) a_in = v; else b_in = v;
  endtask

  function automatic logic [W-1:0] out_of(input int d);
    return (d == 0) ? b_out : a_out;
  endfunction

  function automatic logic [W-1:0] drv_of(input int d);
    return (d == 0) ? W'(b_drive) : W'(a_drive);
  endfunction

  task automatic t_reset_start;
    #1;
    chk("R9 drive A off in reset", W'(a_drive), '0);
    chk("R9 drive B off in reset", W'(b_drive), '0);
    tick; tick;
    rst_n = 1'b1;
    #1;
    chk("R9 A-to-B cleared", b_out, '0);
    chk("R9 B-to-A cleared", a_out, '0);
    chk("R9 drive on after release", W'(b_drive), W'(1));
    exp_store[0] = '0; exp_store[1] = '0;
  endtask

  task automatic t_transp(input int d);
    set_ctl(d, 1'b0, 1'b1, 1'b1, 1'b0);
    set_in(d, 18'h2A5C3 ^ W'(d));
    #1 chk("R3 transparent", out_of(d), 18'h2A5C3 ^ W'(d));
    set_in(d, 18'h20001);
    #1 chk("R1 non-inverting msb/lsb", out_of(d), 18'h20001);
    set_in(d, 18'h3FFFF);
    #1 chk("R1 all ones", out_of(d), 18'h3FFFF);
    chk("R3 drive on", drv_of(d), W'(1));
  endtask

  task automatic t_leave(input int d);
    set_in(d, 18'h1C0DE ^ W'(d));
    tick;
    set_ctl(d, 1'b0, 1'b0, 1'b1, 1'b0);
    set_in(d, 18'h0BEEF);
    exp_store[d] = 18'h1C0DE ^ W'(d);
    #1 chk("R8 keeps last passed word", out_of(d), exp_store[d]);
    tick;
    set_in(d, 18'h33333);
    #1 chk("R4 steady clock holds", out_of(d), exp_store[d]);
  endtask

  task automatic t_capture(input int d);
    set_ctl(d, 1'b0, 1'b0, 1'b0, 1'b1);
    set_in(d, 18'h12345);
    tick;
    #1 chk("R7 rising edge no load", out_of(d), exp_store[d]);
    set_ctl(d, 1'b0, 1'b0, 1'b0, 1'b0);
    set_in(d, 18'h2F0F0 ^ W'(d));
    #1 chk("R5 no load before edge", out_of(d), exp_store[d]);
    tick;
    exp_store[d] = 18'h2F0F0 ^ W'(d);
    #1 chk("R5 falling edge loads", out_of(d), exp_store[d]);
    set_in(d, 18'h00F0F);
    tick;
    #1 chk("R4 hold after load", out_of(d), exp_store[d]);
  endtask

  task automatic t_cke(input int d);
    set_ctl(d, 1'b0, 1'b0, 1'b1, 1'b1);
    tick;
    set_ctl(d, 1'b0, 1'b0, 1'b1, 1'b0);
    set_in(d, 18'h15555);
    tick;
    #1 chk("R6 disabled edge no load", out_of(d), exp_store[d]);
    set_ctl(d, 1'b0, 1'b0, 1'b0, 1'b0);
    tick;
    #1 chk("R6 enable with clock low no load", out_of(d), exp_store[d]);
  endtask

  task automatic t_oe(input int d);
    set_ctl(d, 1'b1, 1'b1, 1'b1, 1'b0);
    set_in(d, 18'h0A0A0);
    #1 chk("R2 drive off", drv_of(d), '0);
    chk("R2 output zero", out_of(d), '0);
    tick;
    set_ctl(d, 1'b1, 1'b0, 1'b0, 1'b1);
    tick;
    set_ctl(d, 1'b1, 1'b0, 1'b0, 1'b0);
    set_in(d, 18'h3C3C3 ^ W'(d));
    tick;
    exp_store[d] = 18'h3C3C3 ^ W'(d);
    #1 chk("R2 still off after load", drv_of(d), '0);
    set_ctl(d, 1'b0, 1'b0, 1'b0, 1'b0);
    #1 chk("R2 loaded word appears", out_of(d), exp_store[d]);
  endtask

  task automatic t_indep;
    set_ctl(1, 1'b0, 1'b0, 1'b0, 1'b1);
    set_in(0, 18'h11111);
    tick;
    set_ctl(1, 1'b0, 1'b0, 1'b0, 1'b0);
    set_in(1, 18'h2DEAD);
    tick;
    exp_store[1] = 18'h2DEAD;
    #1 chk("R10 B-to-A loaded", a_out, exp_store[1]);
    chk("R10 A-to-B untouched", b_out, exp_store[0]);
  endtask

  task automatic t_reset_mid;
    rst_n = 1'b0;
    #1 chk("R9 mid reset A off", W'(a_drive), '0);
    chk("R9 mid reset B off", W'(b_drive), '0);
    tick;
    rst_n = 1'b1;
    #1 chk("R9 A-to-B word cleared", b_out, '0);
    chk("R9 B-to-A word cleared", a_out, '0);
  endtask

  initial begin
    t_reset_start;
    for (int d = 0; d < 2; d++) begin
      t_transp(d);
      t_leave(d);
      t_capture(d);
      t_cke(d);
      t_oe(d);
    end
    t_indep;
    t_reset_mid;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule